// File: doc/BRIEF.md
# Triggered circular trace capture buffer

This block records a stream of trace words into a circular RAM. Capture runs while the enable bit is set. Each accepted word is written at the write pointer, and the pointer then advances. When the pointer steps past the last location it returns to zero and a sticky wrap flag is raised, so a reader can tell where the oldest word sits. A trigger input starts a countdown taken from a programmable post-trigger register. When the countdown runs out, acquisition stops. The RAM then holds a chosen split of history from before and after the trigger.

Software reaches the block through a simple register bus with an address, a write strobe, a read strobe, write data and combinational read data. Through it, software:
- sets the enable and mode bits;
- loads or reads the write pointer;
- sets the post-trigger count;
- polls four status flags;
- reads the RAM back through a read pointer that advances by one on each data read.

A parameter includes or leaves out the paired-beat mode. In that mode two half-width beats are packed into one stored word.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset the control register (offset 0) reads 0, the write pointer (offset 2) reads 0, and the status register (offset 1) reads 0x8. Status bit 0 is wrapped, bit 1 is triggered, bit 2 is acquisition complete and bit 3 is formatter empty.
- R2: With control bit 0 set and bit 1 clear, each cycle with `trace_valid` high stores `trace_word` at the write pointer one cycle later, and the pointer then increments. Writing offset 3 sets the read pointer. Each read of offset 4 with `bus_rd` high returns the word at the read pointer and then increments the read pointer, wrapping at the depth.
- R3: A store at location DEPTH-1 wraps the write pointer to 0 and sets status bit 0. The bit then stays set until capture is enabled again. After a wrap, the oldest word is at the write pointer.
- R4: `trigger_in` sampled high while capture is active sets status bit 1.
- R5: Let N be the post-trigger count written at offset 5, with N > 0. Exactly N words are stored starting with the beat that arrives alongside the trigger. Status bit 2 is then set, and no further beats are stored.
- R6: With N = 0 the trigger ends acquisition at once. The beat that arrives alongside the trigger is not stored.
- R7: Status bit 3 is 0 while capture is active. It rises one cycle after the last pending word is stored once capture has stopped or completed.
- R8: Writing the control register with bit 0 set clears status bits 0, 1 and 2.
- R9: Writing the control register with bit 0 clear stops capture. Later beats leave the write pointer unchanged.
- R10: The write pointer is writable at offset 2. A value of DEPTH or more loads 0.
- R11: Offset 6 reads DEPTH and offset 7 reads the word width W.
- R12: With control bits 1 and 0 both set, consecutive beats are paired into one stored word. The first beat's low W/2 bits form the low half of that word and the second beat's low W/2 bits form the high half. The upper bits of each beat are ignored.
- R13: `trigger_in` is ignored while capture is disabled or already complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_valid | input | 1 | Trace beat present this cycle |
| trace_word | input | W | Trace beat data |
| trigger_in | input | 1 | Trigger event |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; advances the read pointer on offset 4 |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |

## Verification
The hardest case to reach is the end of a post-trigger countdown. Here the beat already sitting in the formatter stage must be discarded rather than stored, and the trigger beat itself must be the first counted word. The bench drives an unbroken burst of beats with the trigger on a chosen beat, for both a nonzero and a zero count. It then checks the final write pointer and reads the RAM back to confirm exactly which beats landed. A wrap case loads more beats than the depth and reads back from the write pointer to confirm the oldest-first order.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_STAT  = 3'd1,
      REG_WPTR  = 3'd2,
      REG_RPTR  = 3'd3,
      REG_DATA  = 3'd4,
      REG_POST  = 3'd5,
      REG_DEPTH = 3'd6,
      REG_WIDTH = 3'd7
   } reg_addr_e;

   localparam int ST_WRAP   = 0;
   localparam int ST_TRIG   = 1;
   localparam int ST_DONE   = 2;
   localparam int ST_FEMPTY = 3;
endpackage

// File: rtl/tcb_formatter.sv
module tcb_formatter #(
   parameter int W         = 16,
   parameter bit HAS_DEMUX = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept,
   input  logic [W-1:0] beat,
   input  logic         demux,
   input  logic         flush,
   output logic         pend_valid,
   output logic [W-1:0] pend_word
);
   localparam int H = W / 2;

   generate
      if (HAS_DEMUX) begin : g_pair
         logic [H-1:0] lo_q;
         logic         have_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_valid <= 1'b0;
               pend_word  <= '0;
               lo_q       <= '0;
               have_q     <= 1'b0;
            end else begin
               pend_valid <= 1'b0;
               if (accept) begin
                  if (demux) begin
                     if (have_q) begin
                        pend_valid <= 1'b1;
                        pend_word  <= {beat[H-1:0], lo_q};
                        have_q     <= 1'b0;
                     end else begin
                        lo_q   <= beat[H-1:0];
                        have_q <= 1'b1;
                     end
                  end else begin
                     pend_valid <= 1'b1;
                     pend_word  <= beat;
                  end
               end
               if (flush) have_q <= 1'b0;
            end
         end
      end else begin : g_plain
         logic unused_in;
         assign unused_in = demux ^ flush;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_valid <= 1'b0;
               pend_word  <= '0;
            end else begin
               pend_valid <= accept;
               if (accept) pend_word <= beat;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_sequencer.sv
module tcb_sequencer #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ctrl_en,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] post_count,
   input  logic             ptr_wr,
   input  logic [AW-1:0]    ptr_val,
   input  logic             pend_valid,
   output logic             active,
   output logic             commit,
   output logic [AW-1:0]    wr_ptr,
   output logic             full,
   output logic             triggered,
   output logic             acq_done,
   output logic             fmt_empty
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [CNT_W-1:0] post_left;

   assign active = ctrl_en & ~acq_done;
   assign commit = pend_valid & ~acq_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         full      <= 1'b0;
         triggered <= 1'b0;
         acq_done  <= 1'b0;
         post_left <= '0;
         fmt_empty <= 1'b1;
      end else begin
         fmt_empty <= ~active & ~pend_valid;
         if (commit) begin
            if (wr_ptr == LAST) begin
               wr_ptr <= '0;
               full   <= 1'b1;
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
            end
            if (triggered) begin
               post_left <= post_left - 1'b1;
               if (post_left <= CNT_W'(1)) acq_done <= 1'b1;
            end
         end
         if (trig_in && active && !triggered) begin
            triggered <= 1'b1;
            post_left <= post_count;
            if (post_count == '0) acq_done <= 1'b1;
         end
         if (ptr_wr) wr_ptr <= ptr_val;
         if (start) begin
            full      <= 1'b0;
            triggered <= 1'b0;
            acq_done  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
   import tcb_pkg::*;
#(
   parameter int W         = 16,
   parameter int DEPTH     = 64,
   parameter int CNT_W     = 16,
   parameter bit HAS_DEMUX = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trace_valid,
   input  logic [W-1:0] trace_word,
   input  logic         trigger_in,
   input  logic         bus_wr,
   input  logic         bus_rd,
   input  logic [2:0]   bus_addr,
   input  logic [31:0]  bus_wdata,
   output logic [31:0]  bus_rdata
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $fatal(1, "DEPTH must be at least 2");
      if (W < 2 || W > 32) $fatal(1, "W must be within 2..32");
      if (CNT_W < 1 || CNT_W > 32) $fatal(1, "CNT_W must be within 1..32");
      if (HAS_DEMUX && (W % 2 != 0)) $fatal(1, "paired mode needs an even W");
   end

   reg_addr_e        addr;
   logic             ctrl_en, ctrl_dmx;
   logic [AW-1:0]    rd_ptr;
   logic [CNT_W-1:0] post_reg;
   logic             start, ptr_wr;
   logic [AW-1:0]    ptr_val;
   logic             active, commit, full, triggered, acq_done, fmt_empty;
   logic [AW-1:0]    wr_ptr;
   logic             pend_valid;
   logic [W-1:0]     pend_word, ram_rdata;
   logic             unused_bits;

   assign addr        = reg_addr_e'(bus_addr);
   assign start       = bus_wr && addr == REG_CTRL && bus_wdata[0];
   assign ptr_wr      = bus_wr && addr == REG_WPTR;
   assign ptr_val     = (bus_wdata < 32'(DEPTH)) ? bus_wdata[AW-1:0] : '0;
   assign unused_bits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ctrl_dmx <= 1'b0;
         rd_ptr   <= '0;
         post_reg <= '0;
      end else begin
         if (bus_wr) begin
            case (addr)
               REG_CTRL: begin
                  ctrl_en  <= bus_wdata[0];
                  ctrl_dmx <= bus_wdata[1] & HAS_DEMUX;
               end
               REG_RPTR: rd_ptr   <= ptr_val;
               REG_POST: post_reg <= bus_wdata[CNT_W-1:0];
               default: ;
            endcase
         end else if (bus_rd && addr == REG_DATA) begin
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         end
      end
   end

   tcb_formatter #(.W(W), .HAS_DEMUX(HAS_DEMUX)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (trace_valid & active),
      .beat       (trace_word),
      .demux      (ctrl_dmx),
      .flush      (start),
      .pend_valid (pend_valid),
      .pend_word  (pend_word)
   );

   tcb_sequencer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ctrl_en    (ctrl_en),
      .trig_in    (trigger_in),
      .post_count (post_reg),
      .ptr_wr     (ptr_wr),
      .ptr_val    (ptr_val),
      .pend_valid (pend_valid),
      .active     (active),
      .commit     (commit),
      .wr_ptr     (wr_ptr),
      .full       (full),
      .triggered  (triggered),
      .acq_done   (acq_done),
      .fmt_empty  (fmt_empty)
   );

   tcb_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (commit),
      .waddr (wr_ptr),
      .wdata (pend_word),
      .raddr (rd_ptr),
      .rdata (ram_rdata)
   );

   always_comb begin
      case (addr)
         REG_CTRL:  bus_rdata = {30'd0, ctrl_dmx, ctrl_en};
         REG_STAT:  bus_rdata = {28'd0, fmt_empty, acq_done, triggered, full};
         REG_WPTR:  bus_rdata = 32'(wr_ptr);
         REG_RPTR:  bus_rdata = 32'(rd_ptr);
         REG_DATA:  bus_rdata = 32'(ram_rdata);
         REG_POST:  bus_rdata = 32'(post_reg);
         REG_DEPTH: bus_rdata = 32'(DEPTH);
         default:   bus_rdata = 32'(W);
      endcase
   end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          ptr_wr,
   input logic [AW-1:0] wr_ptr,
   input logic          full,
   input logic          triggered,
   input logic          acq_done,
   input logic          pend_valid,
   input logic          fmt_empty
);
   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(wr_ptr) < DEPTH); // R2

   AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      full && !start |=> full); // R3

   AST_DONE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      acq_done |-> triggered); // R5

   AST_FROZEN_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      acq_done && !ptr_wr |=> $stable(wr_ptr)); // R5

   AST_EMPTY_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_empty |-> !pend_valid); // R7

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !full && !triggered && !acq_done); // R8
endmodule

bind trace_capture_buffer tcb_checker #(.DEPTH(DEPTH), .AW(AW)) u_tcb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .ptr_wr     (ptr_wr),
   .wr_ptr     (wr_ptr),
   .full       (full),
   .triggered  (triggered),
   .acq_done   (acq_done),
   .pend_valid (pend_valid),
   .fmt_empty  (fmt_empty)
);

// File: tb/trace_capture_buffer_bench.sv
`timescale 1ns/1ps
module trace_capture_buffer_bench;
   localparam int W     = 16;
   localparam int DEPTH = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trace_valid = 1'b0;
   logic [W-1:0] trace_word = '0;
   logic         trigger_in = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q [$];

   always #5 clk = ~clk;

   trace_capture_buffer #(.W(W), .DEPTH(DEPTH), .CNT_W(16), .HAS_DEMUX(1'b1)) u_trace_capture_buffer (
      .clk (clk), .rst_n (rst_n), .trace_valid (trace_valid), .trace_word (trace_word),
      .trigger_in (trigger_in), .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic reg_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      check(tag, v, exp);
   endtask

   // driver: beats with an optional trigger on beat index trig_idx
   task automatic send_beats(input logic [W-1:0] base, input int n, input int trig_idx);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         trace_valid = 1'b1;
         trace_word  = base + W'(i);
         trigger_in  = (i == trig_idx);
      end
      @(negedge clk);
      trace_valid = 1'b0; trigger_in = 1'b0;
   endtask

   // monitor side: read the RAM back and compare against the queue
   task automatic drain_compare(input string tag, input int n);
      logic [31:0] v, e;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_addr = 3'd4; bus_rd = 1'b1;
         #1 v = bus_rdata;
         @(negedge clk);
         bus_rd = 1'b0;
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL %s actual=0x%0h expected=<none>", tag, v);
         end else begin
            e = exp_q.pop_front();
            check(tag, v, e);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R11: reset state and constants
      reg_check("R1 ctrl", 3'd0, 32'h0);
      reg_check("R1 wptr", 3'd2, 32'h0);
      reg_check("R1 status", 3'd1, 32'h8);
      reg_check("R11 depth", 3'd6, 32'(DEPTH));
      reg_check("R11 width", 3'd7, 32'(W));

      // R2: plain capture
      bus_write(3'd5, 32'd100);
      bus_write(3'd2, 32'd0);
      bus_write(3'd0, 32'h1);
      send_beats(16'h1100, 5, -1);
      for (int i = 0; i < 5; i++) exp_q.push_back(32'h1100 + 32'(i));
      reg_check("R2 wptr", 3'd2, 32'd5);
      reg_check("R7 status active", 3'd1, 32'h0);
      bus_write(3'd0, 32'h0);
      reg_check("R7 status stopped", 3'd1, 32'h8);
      bus_write(3'd3, 32'd0);
      drain_compare("R2 readback", 5);

      // R9, R13: stopped capture ignores beats and triggers
      send_beats(16'h7700, 3, 1);
      reg_check("R9 wptr unchanged", 3'd2, 32'd5);
      reg_check("R13 no trigger when off", 3'd1, 32'h8);

      // R10: pointer writes
      bus_write(3'd2, 32'd6);
      reg_check("R10 wptr load", 3'd2, 32'd6);
      bus_write(3'd2, 32'd9);
      reg_check("R10 wptr out of range", 3'd2, 32'd0);

      // R3: wrap
      bus_write(3'd0, 32'h1);
      send_beats(16'h2200, 10, -1);
      reg_check("R3 wptr after wrap", 3'd2, 32'd2);
      reg_check("R3 wrap flag", 3'd1, 32'h1);
      bus_write(3'd0, 32'h0);
      reg_check("R3 wrap sticky", 3'd1, 32'h9);
      bus_write(3'd3, 32'd2);
      for (int i = 2; i < 10; i++) exp_q.push_back(32'h2200 + 32'(i));
      drain_compare("R3 oldest first", 8);

      // R8: enabling clears flags
      bus_write(3'd0, 32'h1);
      reg_check("R8 flags cleared", 3'd1, 32'h0);
      bus_write(3'd0, 32'h0);

      // R4, R5, R13: post-trigger countdown
      bus_write(3'd5, 32'd3);
      bus_write(3'd2, 32'd0);
      bus_write(3'd0, 32'h1);
      send_beats(16'h3300, 10, 4);
      reg_check("R5 wptr after countdown", 3'd2, 32'd7);
      reg_check("R4 R5 status", 3'd1, 32'hE);
      send_beats(16'h3900, 3, 0);
      reg_check("R13 done ignores beats", 3'd2, 32'd7);
      bus_write(3'd0, 32'h0);
      bus_write(3'd3, 32'd0);
      for (int i = 0; i < 7; i++) exp_q.push_back(32'h3300 + 32'(i));
      drain_compare("R5 readback", 7);

      // R6: zero post count
      bus_write(3'd5, 32'd0);
      bus_write(3'd2, 32'd0);
      bus_write(3'd0, 32'h1);
      send_beats(16'h4400, 6, 2);
      reg_check("R6 wptr", 3'd2, 32'd2);
      reg_check("R6 status", 3'd1, 32'hE);
      bus_write(3'd0, 32'h0);
      bus_write(3'd3, 32'd0);
      exp_q.push_back(32'h4400);
      exp_q.push_back(32'h4401);
      drain_compare("R6 readback", 2);

      // R12: paired beats, upper half ignored
      bus_write(3'd5, 32'd100);
      bus_write(3'd2, 32'd0);
      bus_write(3'd0, 32'h3);
      reg_check("R12 ctrl", 3'd0, 32'h3);
      send_beats(16'hAA30, 6, -1);
      reg_check("R12 wptr", 3'd2, 32'd3);
      bus_write(3'd0, 32'h0);
      bus_write(3'd3, 32'd0);
      exp_q.push_back(32'h3130);
      exp_q.push_back(32'h3332);
      exp_q.push_back(32'h3534);
      drain_compare("R12 readback", 3);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule